// File: doc/BRIEF.md
# Indexed Block Register Target for a Two-Wire Management Bus

This block is an SMBus target that holds an eight-byte configuration register file and brings every register out on a parallel bus for the control logic around it. A host moves several registers in one transfer. It names a starting register index and a byte count, and then either streams the data in or turns the bus around with a repeated START and reads it back. A read always opens with the programmed byte count and then gives the register contents. The register index advances after every data byte and wraps from the last register to the first.

The 7-bit target address is one of three values. A three-level strap code picks the value, and the block samples that code once, on the first rising edge of the power-good strobe after reset. Until that edge the block answers no address. SCL and SDA each pass through a two-flop synchroniser and a glitch filter. The block drives SDA only by pulling it low.

Top module: `smbt_cfg_target`

## Requirements
- R1: The target address is 7'h6B when the captured strap code is 2'b00 (low), 7'h6C for 2'b01 (mid), and 7'h6D for 2'b10 or 2'b11 (high). Any other address gets no ACK.
- R2: The strap code is captured only on the first rising edge of `pwr_good_i` after reset. Before that edge no address is ACKed, and later edges do not change the address.
- R3: A block write consists of START, address+W, index N, count X and data bytes. The target ACKs every byte and places the data in registers N to N+X-1, where they appear on `regs_o`. Register k occupies `regs_o[8k+7:8k]`.
- R4: A data byte received after X bytes of a write have been stored is ACKed and discarded.
- R5: A block read consists of START, address+W, index N, repeated START, address+R. The target sends the count byte `{3'b000, reg7[4:0]}` and then the registers from N onward until the host NACKs, after which SDA is released.
- R6: After reset, registers 0 to 7 hold FF, 00, FF, C7, FF, 01, 44, 08 (hex), and SDA is not driven.
- R7: Registers 4, 5 and 6 are read-only and keep FF, 01 and 44. Register 7 stores only bits [4:0], and bits [7:5] read as 0.
- R8: The index advances after every data byte and wraps from 7 to 0. When the index is above 7, written bytes are ACKed and discarded, read bytes return FF, and the index does not advance.
- R9: A START or STOP at any point abandons the current byte and transfer. A START begins address reception again and discards any remaining write count.
- R10: The target changes the state of its SDA pull-down only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| pwr_good_i | input | 1 | Power-good strobe; its first rising edge captures the strap |
| strap_lvl_i | input | 2 | Strap code: 00 low, 01 mid, 1x high |
| regs_o | output | NREG*8 | All register bytes, register k in bits [8k+7:8k] |

## Verification
The hardest situations to reach from the pins are transfers that are cut short. In one, a write stops partway through a data byte. In the other, a repeated START arrives while write count is still left and carries a new count. The bench bit-bangs the bus with its own master tasks. It stops a transfer four bits into a byte and then checks that the register bank is unchanged. It then interleaves two write headers around a repeated START, and the surplus byte must land nowhere. Strap re-capture is reached by toggling `pwr_good_i` again after a different strap code has been applied, and then probing both addresses.

// File: rtl/smbt_pkg.sv
package smbt_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RX,
        PH_RX_ACK,
        PH_TX,
        PH_TX_ACK
    } phase_e;

    typedef enum logic [1:0] {
        RB_ADDR,
        RB_INDEX,
        RB_COUNT,
        RB_DATA
    } rxrole_e;

    // Strap code to 7-bit target address
    function automatic logic [6:0] strap_addr(input logic [1:0] lvl);
        case (lvl)
            2'b00:   strap_addr = 7'h6B;
            2'b01:   strap_addr = 7'h6C;
            default: strap_addr = 7'h6D;
        endcase
    endfunction

    function automatic logic [7:0] reg_init(input int i);
        case (i)
            0:       reg_init = 8'hFF;
            1:       reg_init = 8'h00;
            2:       reg_init = 8'hFF;
            3:       reg_init = 8'hC7;
            4:       reg_init = 8'hFF;
            5:       reg_init = 8'h01;
            6:       reg_init = 8'h44;
            7:       reg_init = 8'h08;
            default: reg_init = 8'h00;
        endcase
    endfunction

    // Bits a host write may change
    function automatic logic [7:0] reg_wmask(input int i);
        case (i)
            4, 5, 6: reg_wmask = 8'h00;
            7:       reg_wmask = 8'h1F;
            default: reg_wmask = 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/smbt_filter.sv
module smbt_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(FILT_LEN + 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [CW-1:0]          cnt;
        logic                   val;
    } flt_t;

    localparam flt_t FLT_RST = '{sync: {SYNC_STAGES{1'b1}}, cnt: '0, val: 1'b1};

    flt_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.sync = {s_q.sync[SYNC_STAGES-2:0], din};
        if (s_q.sync[SYNC_STAGES-1] == s_q.val) begin
            s_d.cnt = '0;
        end else if (s_q.cnt == CW'(FILT_LEN - 1)) begin
            s_d.val = ~s_q.val;
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= FLT_RST;
        else        s_q <= s_d;
    end

    assign dout = s_q.val;

endmodule

// File: rtl/smbt_strap.sv
module smbt_strap
    import smbt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pg_i,
    input  logic [1:0] lvl_i,
    output logic [6:0] addr_o,
    output logic       valid_o
);
    typedef struct packed {
        logic [1:0] sync;
        logic [1:0] lvl;
        logic       valid;
    } stp_t;

    stp_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.sync = {s_q.sync[0], pg_i};
        if (s_q.sync[0] && !s_q.sync[1] && !s_q.valid) begin
            s_d.valid = 1'b1;
            s_d.lvl   = lvl_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign addr_o  = strap_addr(s_q.lvl);
    assign valid_o = s_q.valid;

    // R2: once captured, the strap code never moves again
    a_r2_strap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $past(s_q.valid) |-> (s_q.valid && $stable(s_q.lvl)));

endmodule

// File: rtl/smbt_regfile.sv
module smbt_regfile
    import smbt_pkg::*;
#(
    parameter int NREG = 8,
    localparam int IW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we_i,
    input  logic [IW-1:0]   waddr_i,
    input  logic [7:0]      wdata_i,
    input  logic [IW-1:0]   raddr_i,
    output logic [7:0]      rdata_o,
    output logic [NREG*8-1:0] regs_o
);
    logic [7:0] mem_d [NREG];
    logic [7:0] mem_q [NREG];

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            mem_d[i] = mem_q[i];
            if (we_i && (waddr_i == IW'(i))) begin
                mem_d[i] = (mem_q[i] & ~reg_wmask(i)) | (wdata_i & reg_wmask(i));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem_q[i] <= reg_init(i);
        end else begin
            for (int i = 0; i < NREG; i++) mem_q[i] <= mem_d[i];
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_out
        assign regs_o[g*8 +: 8] = mem_q[g];
    end

    assign rdata_o = mem_q[raddr_i];

    // R7: a write aimed at a read-only location leaves the bank untouched
    a_r7_ro_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && (waddr_i == IW'(4) || waddr_i == IW'(5) || waddr_i == IW'(6)))
        |=> $stable(regs_o));

endmodule

// File: rtl/smbt_link.sv
module smbt_link
    import smbt_pkg::*;
#(
    parameter int NREG = 8,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    input  logic [6:0]    addr_i,
    input  logic          addr_valid_i,
    input  logic [4:0]    count_i,
    input  logic [7:0]    rdata_i,
    output logic [IW-1:0] raddr_o,
    output logic          we_o,
    output logic [IW-1:0] waddr_o,
    output logic [7:0]    wdata_o,
    output logic          sda_oe_o
);
    typedef struct packed {
        phase_e        phase;
        rxrole_e       role;
        logic [3:0]    bitcnt;
        logic [7:0]    sh;
        logic [7:0]    idx;
        logic [7:0]    left;
        logic          go_tx;
        logic          mack;
        logic          scl_p;
        logic          sda_p;
        logic          we;
        logic [IW-1:0] waddr;
        logic [7:0]    wdata;
        logic          oe;
    } lnk_t;

    localparam lnk_t LNK_RST = '{phase: PH_IDLE, role: RB_ADDR, bitcnt: '0, sh: '0,
                                 idx: '0, left: '0, go_tx: 1'b0, mack: 1'b0,
                                 scl_p: 1'b1, sda_p: 1'b1, we: 1'b0, waddr: '0,
                                 wdata: '0, oe: 1'b0};

    lnk_t s_d, s_q;
    logic rise, fall, start, stop, idx_ok;
    logic [7:0] idx_nxt;

    assign rise    = scl_i & ~s_q.scl_p;
    assign fall    = ~scl_i & s_q.scl_p;
    assign start   = scl_i & s_q.scl_p & s_q.sda_p & ~sda_i;
    assign stop    = scl_i & s_q.scl_p & ~s_q.sda_p & sda_i;
    assign idx_ok  = s_q.idx < 8'(NREG);
    assign idx_nxt = (s_q.idx == 8'(NREG - 1)) ? 8'd0 : s_q.idx + 8'd1;

    always_comb begin
        s_d       = s_q;
        s_d.we    = 1'b0;
        s_d.scl_p = scl_i;
        s_d.sda_p = sda_i;
        if (start) begin
            s_d.phase  = PH_RX;
            s_d.role   = RB_ADDR;
            s_d.bitcnt = '0;
            s_d.left   = '0;
        end else if (stop) begin
            s_d.phase = PH_IDLE;
        end else begin
            case (s_q.phase)
                PH_RX: begin
                    if (rise) begin
                        s_d.sh     = {s_q.sh[6:0], sda_i};
                        s_d.bitcnt = s_q.bitcnt + 4'd1;
                    end else if (fall && s_q.bitcnt == 4'd8) begin
                        s_d.phase = PH_RX_ACK;
                        s_d.go_tx = 1'b0;
                        case (s_q.role)
                            RB_ADDR: begin
                                if (addr_valid_i && s_q.sh[7:1] == addr_i) begin
                                    s_d.go_tx = s_q.sh[0];
                                    s_d.role  = RB_INDEX;
                                end else begin
                                    s_d.phase = PH_IDLE;
                                end
                            end
                            RB_INDEX: begin
                                s_d.idx  = s_q.sh;
                                s_d.role = RB_COUNT;
                            end
                            RB_COUNT: begin
                                s_d.left = s_q.sh;
                                s_d.role = RB_DATA;
                            end
                            default: begin
                                if (s_q.left != 8'd0) begin
                                    s_d.left = s_q.left - 8'd1;
                                    if (idx_ok) begin
                                        s_d.we    = 1'b1;
                                        s_d.waddr = s_q.idx[IW-1:0];
                                        s_d.wdata = s_q.sh;
                                        s_d.idx   = idx_nxt;
                                    end
                                end
                            end
                        endcase
                    end
                end
                PH_RX_ACK: begin
                    if (fall) begin
                        s_d.bitcnt = '0;
                        if (s_q.go_tx) begin
                            s_d.phase = PH_TX;
                            s_d.sh    = {3'b000, count_i};
                        end else begin
                            s_d.phase = PH_RX;
                        end
                    end
                end
                PH_TX: begin
                    if (fall) begin
                        if (s_q.bitcnt == 4'd7) begin
                            s_d.phase  = PH_TX_ACK;
                            s_d.bitcnt = '0;
                        end else begin
                            s_d.sh     = {s_q.sh[6:0], 1'b0};
                            s_d.bitcnt = s_q.bitcnt + 4'd1;
                        end
                    end
                end
                PH_TX_ACK: begin
                    if (rise) begin
                        s_d.mack = ~sda_i;
                    end else if (fall) begin
                        if (s_q.mack) begin
                            s_d.phase  = PH_TX;
                            s_d.bitcnt = '0;
                            s_d.sh     = idx_ok ? rdata_i : 8'hFF;
                            if (idx_ok) s_d.idx = idx_nxt;
                        end else begin
                            s_d.phase = PH_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
        s_d.oe = (s_d.phase == PH_RX_ACK) || (s_d.phase == PH_TX && !s_d.sh[7]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= LNK_RST;
        else        s_q <= s_d;
    end

    assign raddr_o  = s_q.idx[IW-1:0];
    assign we_o     = s_q.we;
    assign waddr_o  = s_q.waddr;
    assign wdata_o  = s_q.wdata;
    assign sda_oe_o = s_q.oe;

    // R10: the pull-down only moves while the filtered clock is low
    a_r10_sda_move_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_i);

    // R3: register writes are issued in the low phase of the bus clock
    a_r3_write_in_low: assert property (@(posedge clk) disable iff (!rst_n)
        we_o |-> !scl_i);

    // R9: a START restarts address reception from bit zero
    a_r9_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (s_q.phase == PH_RX && s_q.role == RB_ADDR && s_q.bitcnt == 4'd0));

endmodule

// File: rtl/smbt_cfg_target.sv
module smbt_cfg_target #(
    parameter int NREG        = 8,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic              pwr_good_i,
    input  logic [1:0]        strap_lvl_i,
    output logic [NREG*8-1:0] regs_o
);
    localparam int IW = $clog2(NREG);

    logic          scl_f, sda_f, addr_valid, we;
    logic [6:0]    addr;
    logic [IW-1:0] raddr, waddr;
    logic [7:0]    rdata, wdata;

    smbt_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_scl_flt (
        .clk(clk), .rst_n(rst_n), .din(scl_i), .dout(scl_f));

    smbt_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_sda_flt (
        .clk(clk), .rst_n(rst_n), .din(sda_i), .dout(sda_f));

    smbt_strap u_strap (
        .clk(clk), .rst_n(rst_n), .pg_i(pwr_good_i), .lvl_i(strap_lvl_i),
        .addr_o(addr), .valid_o(addr_valid));

    smbt_regfile #(.NREG(NREG)) u_regs (
        .clk(clk), .rst_n(rst_n), .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
        .raddr_i(raddr), .rdata_o(rdata), .regs_o(regs_o));

    smbt_link #(.NREG(NREG)) u_link (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_f), .sda_i(sda_f),
        .addr_i(addr), .addr_valid_i(addr_valid),
        .count_i(regs_o[(NREG-1)*8 +: 5]), .rdata_i(rdata), .raddr_o(raddr),
        .we_o(we), .waddr_o(waddr), .wdata_o(wdata), .sda_oe_o(sda_oe_o));

endmodule

// File: tb/smbt_cfg_target_tb.sv
module smbt_cfg_target_tb;
    localparam int H = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        pg = 1'b0;
    logic [1:0]  strap = 2'b00;
    logic        sda_oe;
    logic        sda_bus;
    logic [63:0] regs;
    int          n_chk = 0;
    int          n_fail = 0;
    int          viol = 0;
    logic        oe_prev = 1'b0;
    logic        done = 1'b0;

    always #4 clk = ~clk;

    assign sda_bus = m_sda & ~sda_oe;

    smbt_cfg_target u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
        .pwr_good_i(pg), .strap_lvl_i(strap), .regs_o(regs));

    // R10 monitor: pull-down must not move while the bus clock is high
    always @(negedge clk) begin
        if (rst_n && sda_oe !== oe_prev && m_scl) viol++;
        oe_prev <= sda_oe;
    end

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bit_out(input logic b);
        m_sda = b; wt(H/2); m_scl = 1'b1; wt(H); m_scl = 1'b0; wt(H/2);
    endtask

    task automatic m_start();
        m_sda = 1'b1; wt(H/2); m_scl = 1'b1; wt(H); m_sda = 1'b0; wt(H);
        m_scl = 1'b0; wt(H/2);
    endtask

    task automatic m_stop();
        m_sda = 1'b0; wt(H/2); m_scl = 1'b1; wt(H); m_sda = 1'b1; wt(H);
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        m_sda = 1'b1; wt(H/2); m_scl = 1'b1; wt(H/2);
        ack = ~sda_bus; wt(H/2); m_scl = 1'b0; wt(H/2);
    endtask

    task automatic rd_byte(input logic give_ack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wt(H/2); m_scl = 1'b1; wt(H/2); b[i] = sda_bus; wt(H/2);
            m_scl = 1'b0; wt(H/2);
        end
        bit_out(~give_ack);
    endtask

    task automatic probe(input logic [6:0] a, output logic ack);
        m_start(); wr_byte({a, 1'b0}, ack); m_stop();
    endtask

    task automatic blk_write(input logic [6:0] a, input logic [7:0] idx, input logic [7:0] cnt,
                             input logic [7:0] d [8], input int n, output logic ok);
        logic k;
        m_start();
        wr_byte({a, 1'b0}, k); ok = k;
        wr_byte(idx, k); ok &= k;
        wr_byte(cnt, k); ok &= k;
        for (int i = 0; i < n; i++) begin wr_byte(d[i], k); ok &= k; end
        m_stop(); wt(8);
    endtask

    task automatic blk_read(input logic [6:0] a, input logic [7:0] idx, input int n,
                            output logic [7:0] cnt, output logic [7:0] d [8], output logic ok);
        logic k;
        m_start();
        wr_byte({a, 1'b0}, k); ok = k;
        wr_byte(idx, k); ok &= k;
        m_start();
        wr_byte({a, 1'b1}, k); ok &= k;
        rd_byte(1'b1, cnt);
        for (int i = 0; i < 8; i++) d[i] = 8'h00;
        for (int i = 0; i < n; i++) rd_byte(i < n - 1, d[i]);
        m_stop(); wt(8);
    endtask

    task automatic do_reset(input logic [1:0] s, input logic raise_pg);
        rst_n = 1'b0; pg = 1'b0; strap = s; m_scl = 1'b1; m_sda = 1'b1;
        wt(5); rst_n = 1'b1; wt(5);
        if (raise_pg) begin pg = 1'b1; wt(10); end
    endtask

    localparam logic [6:0] A = 7'h6D;
    logic [7:0] z [8] = '{default: 8'h00};

    task automatic t_reset_low();
        logic ack;
        do_reset(2'b00, 1'b0);
        chk("R6 reset bank", regs, 64'h084401FFC7FF00FF);
        chk("R6 sda released", {63'd0, sda_oe}, 64'd0);
        probe(7'h6B, ack);
        chk("R2 no ack before power good", {63'd0, ack}, 64'd0);
        pg = 1'b1; wt(10);
        probe(7'h6B, ack);
        chk("R1 low strap 6B acked", {63'd0, ack}, 64'd1);
        probe(7'h6C, ack);
        chk("R1 low strap 6C ignored", {63'd0, ack}, 64'd0);
    endtask

    task automatic t_strap_mid();
        logic ack;
        do_reset(2'b01, 1'b1);
        probe(7'h6C, ack);
        chk("R1 mid strap 6C acked", {63'd0, ack}, 64'd1);
        strap = 2'b10; pg = 1'b0; wt(10); pg = 1'b1; wt(10);
        probe(7'h6C, ack);
        chk("R2 no recapture keeps 6C", {63'd0, ack}, 64'd1);
        probe(7'h6D, ack);
        chk("R2 no recapture 6D ignored", {63'd0, ack}, 64'd0);
    endtask

    task automatic t_strap_high();
        logic ack;
        do_reset(2'b10, 1'b1);
        probe(A, ack);
        chk("R1 high strap 6D acked", {63'd0, ack}, 64'd1);
    endtask

    task automatic t_write();
        logic ok;
        blk_write(A, 8'd0, 8'd4, '{8'hA0, 8'hA1, 8'hA2, 8'hA3, 0, 0, 0, 0}, 4, ok);
        chk("R3 all bytes acked", {63'd0, ok}, 64'd1);
        chk("R3 regs 0..3", {32'd0, regs[31:0]}, 64'hA3A2A1A0);
    endtask

    task automatic t_overrun();
        logic ok;
        blk_write(A, 8'd2, 8'd1, '{8'h55, 8'h66, 0, 0, 0, 0, 0, 0}, 2, ok);
        chk("R4 surplus byte acked", {63'd0, ok}, 64'd1);
        chk("R4 only counted byte stored", {48'd0, regs[31:16]}, 64'hA355);
    endtask

    task automatic t_readonly();
        logic ok;
        blk_write(A, 8'd4, 8'd4, '{8'h11, 8'h22, 8'h33, 8'h9F, 0, 0, 0, 0}, 4, ok);
        chk("R7 regs 4..6 unchanged", {40'd0, regs[55:32]}, 64'h4401FF);
        chk("R7 reg7 upper bits zero", {56'd0, regs[63:56]}, 64'h1F);
        blk_write(A, 8'd7, 8'd1, '{8'h08, 0, 0, 0, 0, 0, 0, 0}, 1, ok);
    endtask

    task automatic t_read();
        logic ok; logic [7:0] cnt; logic [7:0] d [8];
        blk_read(A, 8'd0, 8, cnt, d, ok);
        chk("R5 read header acked", {63'd0, ok}, 64'd1);
        chk("R5 count byte first", {56'd0, cnt}, 64'h08);
        chk("R5 register stream", {d[7], d[6], d[5], d[4], d[3], d[2], d[1], d[0]},
            64'h084401FFA355A1A0);
        chk("R5 sda released after nack", {63'd0, sda_oe}, 64'd0);
    endtask

    task automatic t_wrap();
        logic ok; logic [7:0] cnt; logic [7:0] d [8];
        blk_write(A, 8'd6, 8'd3, '{8'h11, 8'h05, 8'h77, 0, 0, 0, 0, 0}, 3, ok);
        chk("R8 write wraps 7 to 0", {regs[63:48], regs[7:0]}, {8'h05, 8'h44, 8'h77});
        blk_read(A, 8'd7, 3, cnt, d, ok);
        chk("R8 count follows reg7", {56'd0, cnt}, 64'h05);
        chk("R8 read wraps 7 to 0", {40'd0, d[0], d[1], d[2]}, 64'h0577A1);
        blk_write(A, 8'd7, 8'd1, '{8'h08, 0, 0, 0, 0, 0, 0, 0}, 1, ok);
    endtask

    task automatic t_high_index();
        logic ok; logic [7:0] cnt; logic [7:0] d [8]; logic [63:0] snap;
        snap = regs;
        blk_write(A, 8'd9, 8'd2, '{8'h12, 8'h34, 0, 0, 0, 0, 0, 0}, 2, ok);
        chk("R8 out-of-range write acked", {63'd0, ok}, 64'd1);
        chk("R8 out-of-range write discarded", regs, snap);
        blk_read(A, 8'd9, 2, cnt, d, ok);
        chk("R8 out-of-range read FF", {48'd0, d[0], d[1]}, 64'hFFFF);
    endtask

    task automatic t_abort();
        logic k; logic [63:0] snap;
        m_start(); wr_byte({A, 1'b0}, k); wr_byte(8'd1, k); wr_byte(8'd2, k);
        wr_byte(8'h5A, k);
        for (int i = 7; i >= 4; i--) bit_out(1'b1);
        m_stop(); wt(8);
        chk("R9 stop mid-byte keeps partial out", {48'd0, regs[23:8]}, 64'h555A);
        snap = regs;
        m_start(); wr_byte({A, 1'b0}, k); wr_byte(8'd3, k); wr_byte(8'd2, k);
        wr_byte(8'h3C, k);
        m_start(); wr_byte({A, 1'b0}, k); wr_byte(8'd2, k); wr_byte(8'd1, k);
        wr_byte(8'h99, k); wr_byte(8'hEE, k);
        m_stop(); wt(8);
        chk("R9 repeated start resets count", {40'd0, regs[39:16]}, {40'd0, snap[39:32], 8'h3C, 8'h99});
    endtask

    initial begin
        t_reset_low();
        t_strap_mid();
        t_strap_high();
        t_write();
        t_overrun();
        t_readonly();
        t_read();
        t_wrap();
        t_high_index();
        t_abort();
        chk("R10 no pull-down change with SCL high", viol, 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule